// File: doc/BRIEF.md
# Run-Length Sample Compressor

This block sits in front of a capture memory and shrinks a stream of probed samples by merging runs of equal values. Each cycle in which the clock qualifier is high supplies one sample. The block keeps one pending entry, made of a value and a repeat count. The entry is extended while the same value keeps arriving. The entry is written out when the value changes, when its count cannot grow any further, or when the owner forces it out.

Each emitted entry is one word that carries the repeat count in its upper field and the sample value in its lower field. The word is presented together with a single-cycle write strobe, ready for the memory addressing logic to store. The owner pulses the flush input at the trigger and at the end of a capture. This pushes out the pending run, so that the trigger sample always begins an entry of its own.

Top module: `rle_compressor`

## Requirements
- R1: While rst_ni is low and after it is released, entry_valid_o is 0 and entry_o is all zeros until the first entry is emitted; no entry is pending after reset.
- R2: An entry is the word {count, value}: the count is in entry_o[DATA_W+CNT_W-1:DATA_W] and the value is in entry_o[DATA_W-1:0]. The count equals the number of qualified samples merged into the entry, so 1 means one occurrence and 0 never appears. The first qualified sample after reset or after a flush opens an entry with count 1.
- R3: A qualified sample equal to the pending value increments the count. A qualified sample that differs from the pending value emits the pending entry and opens a new entry with count 1 for the new value.
- R4: When the pending count equals 2^CNT_W-1 and another qualified sample of the same value arrives, the entry is emitted with count 2^CNT_W-1. That sample then opens a fresh entry with count 1 for the same value.
- R5: Cycles with qual_i low and flush_i low are ignored: data_i is not looked at, nothing is counted, the run is not split, and no entry is emitted.
- R6: flush_i high emits the pending entry, even if the value has not changed. If qual_i is also high in that cycle, the sample starts a new entry with count 1. Otherwise nothing is pending afterwards.
- R7: flush_i high with no entry pending emits nothing.
- R8: entry_valid_o is high for exactly one cycle per entry, in the cycle after the clock edge that samples the triggering input. entry_o holds its last value while entry_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| qual_i | input | 1 | Clock qualifier; a cycle with this high delivers one sample |
| data_i | input | DATA_W | Probed sample value |
| flush_i | input | 1 | Forces the pending entry out |
| entry_o | output | CNT_W+DATA_W | Emitted entry {count, value} |
| entry_valid_o | output | 1 | One-cycle write strobe for entry_o |

## Verification
The bench builds the block with DATA_W = 8 and CNT_W = 8. With these values the saturation count is 255, so runs of 253 to 766 samples cross one, two and three counter wrap-arounds in a few thousand cycles. All 256 sample values are also swept as back-to-back changes. Expected entry lists are computed arithmetically from each run's length and value. These runs are combined with idle qualifier gaps that carry decoy data, flushes that coincide with a sample, and flushes with nothing pending.

// File: rtl/rle_pkg.sv
package rle_pkg;
  // Reason a pending entry leaves the tracker
  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_CHANGE = 2'd1,
    EV_SAT    = 2'd2,
    EV_FLUSH  = 2'd3
  } emit_ev_e;
endpackage

// File: rtl/rle_run_tracker.sv
module rle_run_tracker
  import rle_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              qual_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              flush_i,
  output emit_ev_e          ev_o,
  output logic              have_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [DATA_W-1:0] val_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic              have_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] val_q;
  logic              match, sat, bump, open;

  assign match = (data_i == val_q);
  assign sat   = (cnt_q == CNT_MAX);
  assign bump  = qual_i && !flush_i && have_q && match && !sat;
  assign open  = (qual_i || flush_i) && !bump;

  always_comb begin
    ev_o = EV_NONE;
    if (have_q) begin
      if (flush_i)                 ev_o = EV_FLUSH;
      else if (qual_i && !match)   ev_o = EV_CHANGE;
      else if (qual_i && sat)      ev_o = EV_SAT;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q <= 1'b0;
      cnt_q  <= '0;
      val_q  <= '0;
    end else if (bump) begin
      cnt_q <= cnt_q + CNT_ONE;
    end else if (open) begin
      // flush without a sample leaves nothing pending
      have_q <= qual_i;
      cnt_q  <= qual_i ? CNT_ONE : '0;
      if (qual_i) val_q <= data_i;
    end
  end

  assign have_o = have_q;
  assign cnt_o  = cnt_q;
  assign val_o  = val_q;

  assert_skip_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!qual_i && !flush_i) |=> ($stable(cnt_q) && $stable(val_q) && $stable(have_q)));

  assert_merge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qual_i && !flush_i && have_q && match && !sat) |=> (cnt_q == $past(cnt_q) + CNT_ONE));
endmodule

// File: rtl/rle_entry_reg.sv
module rle_entry_reg #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    emit_i,
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic [DATA_W-1:0]       val_i,
  output logic [CNT_W+DATA_W-1:0] entry_o,
  output logic                    valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      entry_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= emit_i;
      if (emit_i) entry_o <= {cnt_i, val_i};
    end
  end

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !emit_i |=> ($stable(entry_o) && !valid_o));
endmodule

// File: rtl/rle_compressor.sv
module rle_compressor
  import rle_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    qual_i,
  input  logic [DATA_W-1:0]       data_i,
  input  logic                    flush_i,
  output logic [CNT_W+DATA_W-1:0] entry_o,
  output logic                    entry_valid_o
);
  localparam int               ENTRY_W = CNT_W + DATA_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  emit_ev_e          ev;
  logic              run_have;
  logic [CNT_W-1:0]  run_cnt;
  logic [DATA_W-1:0] run_val;

  rle_run_tracker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_track (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .qual_i (qual_i),
    .data_i (data_i),
    .flush_i(flush_i),
    .ev_o   (ev),
    .have_o (run_have),
    .cnt_o  (run_cnt),
    .val_o  (run_val)
  );

  rle_entry_reg #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .emit_i (ev != EV_NONE),
    .cnt_i  (run_cnt),
    .val_i  (run_val),
    .entry_o(entry_o),
    .valid_o(entry_valid_o)
  );

  assert_nonzero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_valid_o |-> (entry_o[ENTRY_W-1:DATA_W] != '0));

  assert_change_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qual_i && !flush_i && run_have && data_i != run_val)
    |=> (entry_valid_o && entry_o[DATA_W-1:0] == $past(run_val) && run_cnt == 1));

  assert_sat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qual_i && !flush_i && run_have && data_i == run_val && run_cnt == CNT_MAX)
    |=> (entry_valid_o && entry_o[ENTRY_W-1:DATA_W] == CNT_MAX && run_cnt == 1));

  assert_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!qual_i && !flush_i) |=> !entry_valid_o);

  assert_flush_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && run_have) |=> (entry_valid_o && run_have == $past(qual_i)));

  assert_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && !run_have) |=> !entry_valid_o);
endmodule

// File: tb/rle_compressor_tb.sv
module rle_compressor_tb;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam int EW = DW + CW;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic qual = 1'b0;
  logic flush = 1'b0;
  logic [DW-1:0] data = '0;
  logic [EW-1:0] entry;
  logic entry_valid;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  logic [EW-1:0] exp_e [0:4095];
  string exp_t [0:4095];
  int wr = 0;
  int rd = 0;

  always #5 clk = ~clk;

  rle_compressor #(.DATA_W(DW), .CNT_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .qual_i(qual), .data_i(data),
    .flush_i(flush), .entry_o(entry), .entry_valid_o(entry_valid)
  );

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        $display("FAIL watchdog expired: actual %0d cycles expected < 150000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad + 1);
        $finish;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [EW-1:0] act, input logic [EW-1:0] ex);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, ex);
    end
  endtask

  task automatic expect_e(input int cnt, input int val, input string tag);
    exp_e[wr] = {cnt[CW-1:0], val[DW-1:0]};
    exp_t[wr] = tag;
    wr++;
  endtask

  // Check the output produced by the previous step, then drive the next one
  task automatic observe();
    if (entry_valid) begin
      if (rd < wr) begin
        chk(entry == exp_e[rd], exp_t[rd], entry, exp_e[rd]);
        rd++;
      end else begin
        chk(1'b0, "R8 unexpected entry", entry, '0);
      end
    end
  endtask

  task automatic step(input bit q, input int d, input bit f);
    @(negedge clk);
    observe();
    qual = q;
    data = d[DW-1:0];
    flush = f;
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 3; i++) step(1'b0, 8'hA5, 1'b0);
    chk(rd == wr, tag, EW'(rd), EW'(wr));
    rd = 0;
    wr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(entry_valid == 1'b0 && entry == '0, "R1 during reset", entry, '0);
    rst_n = 1'b1;
    step(1'b0, 0, 1'b0);
    step(1'b0, 0, 1'b0);
    chk(entry_valid == 1'b0 && entry == '0, "R1 after reset", entry, '0);
    // R7 flush right after reset: nothing pending
    step(1'b0, 0, 1'b1);
    step(1'b0, 0, 1'b1);
    drain("R7 flush with empty state");

    // R2/R3/R4: runs of known length, split arithmetically at 255
    for (int s = 0; s < 3; s++) begin
      int lo = (s == 0) ? 1 : (s == 1) ? 253 : 508;
      int hi = (s == 0) ? 20 : (s == 1) ? 258 : 512;
      for (int len = lo; len <= hi; len++) begin
        int v = (len & 255) ^ 8'h5A;
        for (int k = 0; k < len / MAXC; k++) expect_e(MAXC, v, "R4 saturated run");
        if (len % MAXC != 0) expect_e(len % MAXC, v, "R2 run remainder");
        for (int k = 0; k < len; k++) step(1'b1, v, 1'b0);
        step(1'b0, 0, 1'b1);
      end
      drain("R4 run entry count");
    end
    for (int len = 765; len <= 766; len++) begin
      for (int k = 0; k < len / MAXC; k++) expect_e(MAXC, 8'h3C, "R4 triple wrap");
      if (len % MAXC != 0) expect_e(len % MAXC, 8'h3C, "R4 triple remainder");
      for (int k = 0; k < len; k++) step(1'b1, 8'h3C, 1'b0);
      step(1'b0, 0, 1'b1);
      drain("R4 triple wrap count");
    end

    // R3: every value changes, each entry count 1
    for (int v = 0; v < 256; v++) begin
      expect_e(1, v, "R3 change sweep");
      step(1'b1, v, 1'b0);
    end
    step(1'b0, 0, 1'b1);
    drain("R3 change sweep count");

    // R3: adjacent runs of different lengths without flush
    for (int v = 1; v <= 30; v++) begin
      expect_e(v, v * 7, "R3 adjacent runs");
      for (int k = 0; k < v; k++) step(1'b1, v * 7, 1'b0);
    end
    step(1'b0, 0, 1'b1);
    drain("R3 adjacent runs count");

    // R5: qualifier gaps with decoy data do not split or count
    for (int k = 1; k <= 40; k++) begin
      int w = k + 100;
      expect_e(k, w, "R5 gapped run");
      for (int j = 0; j < k; j++) begin
        step(1'b1, w, 1'b0);
        for (int g = 0; g <= (j % 3); g++) step(1'b0, ~w, 1'b0);
      end
      step(1'b0, 0, 1'b1);
    end
    drain("R5 gapped run count");

    // R6: flush coinciding with a sample starts a new entry
    expect_e(5, 8'h33, "R6 flush splits run");
    expect_e(4, 8'h33, "R6 flush sample opens entry");
    for (int k = 0; k < 5; k++) step(1'b1, 8'h33, 1'b0);
    step(1'b1, 8'h33, 1'b1);
    for (int k = 0; k < 3; k++) step(1'b1, 8'h33, 1'b0);
    step(1'b0, 0, 1'b1);
    drain("R6 flush split count");

    // R6/R7: flush with sample from empty, then repeated flushes
    expect_e(1, 8'hC7, "R6 flush from empty");
    expect_e(1, 8'hC8, "R6 back-to-back flush");
    step(1'b1, 8'hC7, 1'b1);
    step(1'b1, 8'hC8, 1'b1);
    step(1'b0, 0, 1'b1);
    step(1'b0, 0, 1'b1);
    drain("R7 repeated flush count");

    // R8: entry_o holds last value while strobe low
    step(1'b0, 0, 1'b0);
    chk(entry_valid == 1'b0 && entry == {8'd1, 8'hC8}, "R8 hold", entry, {8'd1, 8'hC8});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule